// File: doc/BRIEF.md
# Serial Configuration Receiver for a Dual-Bridge Stepper Driver

This block receives configuration for a two-bridge microstepping motor driver over a three-wire port made of a serial clock, a data line and a strobe. A host pulls the strobe low and clocks in a 19-bit frame. The last bit of the frame picks one of two configuration words. When the strobe goes back high, the other 18 bits are loaded into the chosen word. The held words are decoded onto plain output pins: per-bridge current codes, phases and decay modes, reference and range selects, PWM timing fields, oscillator divider and rectifier mode, test bits and an idle request.

All three serial pins are asynchronous to the block clock. They are synchronised and edge-detected inside the block. The serial port is a fixed-timing protocol with no flow control. The host cannot be stalled, so the block has no back-pressure path: a frame is accepted or dropped in full when the strobe rises. Configuration outputs are plain level signals. They are valid from reset and change only on an accepted frame or a clear.

A low-power sleep input and an undervoltage flag each clear both words, and the shift state, asynchronously.

Top module: `stepcfg_port`

## Requirements
- R1: A frame is 19 bits, sent highest first (D18 down to D0). Bits are sampled on rising edges of `ser_clk` while `ser_strobe` is low. Rising `ser_clk` edges while `ser_strobe` is high have no effect on any output.
- R2: A falling edge of `ser_strobe` empties the shifter and zeroes its bit count. Bits left over from an earlier aborted frame do not affect the next frame.
- R3: On a rising edge of `ser_strobe` after exactly 19 bits, D18..D1 are loaded into word 0 when D0=0, or into word 1 when D0=1. The other word keeps its value.
- R4: Word 0 decodes as follows. D6..D1 give `br1_code` (D1 is the LSB). D12..D7 give `br2_code`. D13 is `br1_phase` and D14 is `br2_phase`. D15 is `br1_slow` and D16 is `br2_slow` (1 = slow decay, 0 = mixed). D17 is `ref_ext`. D18 is `range_div4` (1 = divide by 4, 0 = divide by 8).
- R5: Word 1 decodes as follows. D2..D1 give `blank_sel`. D7..D3 give `off_time`. D11..D8 give `fast_time`. D13..D12 give `osc_sel`. D15..D14 give `rect_mode`. D17..D16 give `test_bits`. `idle` is high when D18 is 0.
- R6: If the strobe rises after any bit count other than 19 (fewer or more), nothing is loaded and both words are unchanged.
- R7: `br1_off` is high exactly when `br1_code` is zero. `br2_off` is high exactly when `br2_code` is zero.
- R8: `sleep_n` low or `uvlo` high clears both words to zero without waiting for a clock edge. While cleared, `idle`, `br1_off` and `br2_off` are high.
- R9: After reset every decoded field is zero, and `idle`, `br1_off` and `br2_off` are high.
- R10: The outputs show a newly accepted word no more than 4 `clk` cycles after the rising strobe edge at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_n | input | 1 | Active-low sleep; clears all configuration |
| uvlo | input | 1 | Undervoltage flag; clears all configuration |
| ser_clk | input | 1 | Serial clock; data sampled on its rising edge |
| ser_data | input | 1 | Serial data, highest bit first |
| ser_strobe | input | 1 | Frame strobe, idles high, low during a write |
| br1_code | output | 6 | Bridge 1 current code |
| br2_code | output | 6 | Bridge 2 current code |
| br1_phase | output | 1 | Bridge 1 current direction |
| br2_phase | output | 1 | Bridge 2 current direction |
| br1_slow | output | 1 | Bridge 1 decay mode, 1 = slow |
| br2_slow | output | 1 | Bridge 2 decay mode, 1 = slow |
| ref_ext | output | 1 | Reference source select |
| range_div4 | output | 1 | Sense range, 1 = divide by 4 |
| br1_off | output | 1 | Bridge 1 disabled (zero code) |
| br2_off | output | 1 | Bridge 2 disabled (zero code) |
| blank_sel | output | 2 | Comparator blanking select |
| off_time | output | 5 | Fixed off-time code |
| fast_time | output | 4 | Fast-decay time code |
| osc_sel | output | 2 | Oscillator divider control |
| rect_mode | output | 2 | Synchronous rectifier mode |
| test_bits | output | 2 | Test bits, passed through |
| idle | output | 1 | Idle request, high when word 1 D18 is 0 |

## Verification
The bench targets frames of 18 and 20 bits. A design with a loose count check would load a shifted word there. It also sends a frame right after an aborted partial write: if the shifter were not cleared on the falling strobe, that valid frame would be dropped or misaligned. Writes to each word check that the other word stays intact, which catches a design that decodes the select bit wrongly or writes both banks. Clock pulses with the strobe high, and sleep and undervoltage clears, show whether stray edges are shifted in and whether `idle` and the bridge-off pins come back high.

// File: rtl/stepcfg_pkg.sv
package stepcfg_pkg;
  localparam int FRAME_LEN = 19;
  localparam int DATA_W    = FRAME_LEN - 1;
  localparam int CODE_W    = 6;
  localparam int NBANK     = 2;
  localparam int SEL_W     = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int CNT_MAX   = FRAME_LEN + 1;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  // word 0, packed so bit k of the struct is frame bit D(k+1)
  typedef struct packed {
    logic              range_div4;
    logic              ref_ext;
    logic              br2_slow;
    logic              br1_slow;
    logic              br2_phase;
    logic              br1_phase;
    logic [CODE_W-1:0] br2_code;
    logic [CODE_W-1:0] br1_code;
  } drive_word_t;

  // word 1, same packing rule
  typedef struct packed {
    logic       run;
    logic [1:0] test_bits;
    logic [1:0] rect_mode;
    logic [1:0] osc_sel;
    logic [3:0] fast_time;
    logic [4:0] off_time;
    logic [1:0] blank_sel;
  } timing_word_t;
endpackage

// File: rtl/stepcfg_sync.sv
module stepcfg_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) pipe <= {STAGES{RST_VAL[i]}};
      else        pipe <= {pipe[STAGES-2:0], d[i]};
    end
    assign q[i] = pipe[STAGES-1];
  end
endmodule

// File: rtl/stepcfg_shifter.sv
module stepcfg_shifter
  import stepcfg_pkg::*;
(
  input  logic              clk,
  input  logic              clr_n,
  input  logic              sclk_s,
  input  logic              sdata_s,
  input  logic              stb_s,
  output logic              commit,
  output logic [SEL_W-1:0]  commit_sel,
  output logic [DATA_W-1:0] commit_data,
  output logic [CNT_W-1:0]  bit_cnt
);
  logic                 sclk_d, stb_d;
  logic                 sclk_rise, stb_rise, stb_fall;
  logic [FRAME_LEN-1:0] sh;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      sclk_d <= 1'b0;
      stb_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      stb_d  <= stb_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign stb_rise  = stb_s & ~stb_d;
  assign stb_fall  = ~stb_s & stb_d;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      sh      <= '0;
      bit_cnt <= '0;
    end else if (stb_fall) begin
      sh      <= '0;
      bit_cnt <= '0;
    end else if (sclk_rise && !stb_s) begin
      sh <= {sh[FRAME_LEN-2:0], sdata_s};
      if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign commit      = stb_rise && (bit_cnt == CNT_W'(FRAME_LEN));
  assign commit_sel  = SEL_W'(sh[0]);
  assign commit_data = sh[FRAME_LEN-1:1];
endmodule

// File: rtl/stepcfg_bank.sv
module stepcfg_bank
  import stepcfg_pkg::*;
(
  input  logic                         clk,
  input  logic                         clr_n,
  input  logic                         commit,
  input  logic [SEL_W-1:0]             sel,
  input  logic [DATA_W-1:0]            data,
  output logic [NBANK-1:0][DATA_W-1:0] bank_q
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)                              bank_q[b] <= '0;
      else if (commit && sel == SEL_W'(b))     bank_q[b] <= data;
    end
  end
endmodule

// File: rtl/stepcfg_port.sv
module stepcfg_port
  import stepcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_n,
  input  logic              uvlo,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_strobe,
  output logic [CODE_W-1:0] br1_code,
  output logic [CODE_W-1:0] br2_code,
  output logic              br1_phase,
  output logic              br2_phase,
  output logic              br1_slow,
  output logic              br2_slow,
  output logic              ref_ext,
  output logic              range_div4,
  output logic              br1_off,
  output logic              br2_off,
  output logic [1:0]        blank_sel,
  output logic [4:0]        off_time,
  output logic [3:0]        fast_time,
  output logic [1:0]        osc_sel,
  output logic [1:0]        rect_mode,
  output logic [1:0]        test_bits,
  output logic              idle
);
  logic                         clr_n;
  logic [2:0]                   pins_s;
  logic                         commit;
  logic [SEL_W-1:0]             commit_sel;
  logic [DATA_W-1:0]            commit_data;
  logic [CNT_W-1:0]             bit_cnt;
  logic [NBANK-1:0][DATA_W-1:0] bank_q;
  logic [DATA_W-1:0]            w0_bits, w1_bits;
  drive_word_t                  w0;
  timing_word_t                 w1;

  // sleep and undervoltage act as asynchronous clears alongside reset
  assign clr_n = rst_n & sleep_n & ~uvlo;

  stepcfg_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .clr_n (clr_n),
    .d     ({ser_strobe, ser_data, ser_clk}),
    .q     (pins_s)
  );

  stepcfg_shifter u_shift (
    .clk         (clk),
    .clr_n       (clr_n),
    .sclk_s      (pins_s[0]),
    .sdata_s     (pins_s[1]),
    .stb_s       (pins_s[2]),
    .commit      (commit),
    .commit_sel  (commit_sel),
    .commit_data (commit_data),
    .bit_cnt     (bit_cnt)
  );

  stepcfg_bank u_bank (
    .clk    (clk),
    .clr_n  (clr_n),
    .commit (commit),
    .sel    (commit_sel),
    .data   (commit_data),
    .bank_q (bank_q)
  );

  assign w0_bits = bank_q[0];
  assign w1_bits = bank_q[1];
  assign w0      = drive_word_t'(w0_bits);
  assign w1      = timing_word_t'(w1_bits);

  assign br1_code   = w0.br1_code;
  assign br2_code   = w0.br2_code;
  assign br1_phase  = w0.br1_phase;
  assign br2_phase  = w0.br2_phase;
  assign br1_slow   = w0.br1_slow;
  assign br2_slow   = w0.br2_slow;
  assign ref_ext    = w0.ref_ext;
  assign range_div4 = w0.range_div4;
  assign br1_off    = (w0.br1_code == '0);
  assign br2_off    = (w0.br2_code == '0);

  assign blank_sel  = w1.blank_sel;
  assign off_time   = w1.off_time;
  assign fast_time  = w1.fast_time;
  assign osc_sel    = w1.osc_sel;
  assign rect_mode  = w1.rect_mode;
  assign test_bits  = w1.test_bits;
  assign idle       = ~w1.run;
endmodule

// File: rtl/stepcfg_chk.sv
module stepcfg_chk
  import stepcfg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_n,
  input logic              uvlo,
  input logic              clr_n,
  input logic              commit,
  input logic [SEL_W-1:0]  commit_sel,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [DATA_W-1:0] w0_bits,
  input logic [DATA_W-1:0] w1_bits,
  input logic              idle,
  input logic              br1_off,
  input logic              br2_off
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!clr_n)
    bit_cnt <= CNT_W'(CNT_MAX)); // R6

  AST_SEL0_KEEPS_W1: assert property (@(posedge clk) disable iff (!clr_n)
    (commit && commit_sel == '0) |=> $stable(w1_bits)); // R3

  AST_SEL1_KEEPS_W0: assert property (@(posedge clk) disable iff (!clr_n)
    (commit && commit_sel != '0) |=> $stable(w0_bits)); // R3

  AST_NO_COMMIT_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
    !commit |=> ($stable(w0_bits) && $stable(w1_bits))); // R6

  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!clr_n)
    commit |=> !commit); // R3

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_n || uvlo) |-> (w0_bits == '0 && w1_bits == '0)); // R8

  AST_CLEAR_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_n || uvlo) |-> (idle && br1_off && br2_off)); // R8
endmodule

bind stepcfg_port stepcfg_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sleep_n    (sleep_n),
  .uvlo       (uvlo),
  .clr_n      (clr_n),
  .commit     (commit),
  .commit_sel (commit_sel),
  .bit_cnt    (bit_cnt),
  .w0_bits    (w0_bits),
  .w1_bits    (w1_bits),
  .idle       (idle),
  .br1_off    (br1_off),
  .br2_off    (br2_off)
);

// File: tb/sim_stepcfg_port.sv
`timescale 1ns/1ps
module sim_stepcfg_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0, sleep_n = 1'b1, uvlo = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b1;
  logic [5:0] br1_code, br2_code;
  logic br1_phase, br2_phase, br1_slow, br2_slow, ref_ext, range_div4;
  logic br1_off, br2_off, idle;
  logic [1:0] blank_sel, osc_sel, rect_mode, test_bits;
  logic [4:0] off_time;
  logic [3:0] fast_time;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [17:0] exp_w0 = '0, exp_w1 = '0;

  always #2.5 clk = ~clk;

  stepcfg_port u0 (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .uvlo(uvlo),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_strobe(ser_strobe),
    .br1_code(br1_code), .br2_code(br2_code),
    .br1_phase(br1_phase), .br2_phase(br2_phase),
    .br1_slow(br1_slow), .br2_slow(br2_slow),
    .ref_ext(ref_ext), .range_div4(range_div4),
    .br1_off(br1_off), .br2_off(br2_off),
    .blank_sel(blank_sel), .off_time(off_time), .fast_time(fast_time),
    .osc_sel(osc_sel), .rect_mode(rect_mode), .test_bits(test_bits),
    .idle(idle)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // every output against the bench model, field positions per R4/R5/R7
  task automatic check_all(input string req);
    logic [37:0] e, a;
    e = {exp_w0[5:0], exp_w0[11:6], exp_w0[12], exp_w0[13], exp_w0[14],
         exp_w0[15], exp_w0[16], exp_w0[17], exp_w0[5:0] == 6'd0,
         exp_w0[11:6] == 6'd0, exp_w1[1:0], exp_w1[6:2], exp_w1[10:7],
         exp_w1[12:11], exp_w1[14:13], exp_w1[16:15], ~exp_w1[17]};
    a = {br1_code, br2_code, br1_phase, br2_phase, br1_slow, br2_slow,
         ref_ext, range_div4, br1_off, br2_off, blank_sel, off_time,
         fast_time, osc_sel, rect_mode, test_bits, idle};
    check(req, 64'(a), 64'(e));
  endtask

  // shift n bits, highest first, from bits[n-1] down to bits[0]
  task automatic shift_bits(input logic [23:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = bits[i];
      tick(4);
      ser_clk = 1'b1;
      tick(4);
      ser_clk = 1'b0;
    end
  endtask

  task automatic frame(input logic [23:0] bits, input int n);
    ser_strobe = 1'b0;
    tick(6);
    shift_bits(bits, n);
    tick(2);
    ser_strobe = 1'b1;
    tick(4);   // R10: outputs settled within 4 clk of the strobe rise
  endtask

  task automatic write_word(input logic sel, input logic [17:0] d);
    frame({5'd0, d, sel}, 19);
    if (sel) exp_w1 = d; else exp_w0 = d;
  endtask

  task automatic t_reset;
    check_all("R9 reset state");
  endtask

  task automatic t_word0;
    // range=1 ref=0 slow2=1 slow1=0 ph2=0 ph1=1 code2=15 code1=2A
    write_word(1'b0, {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 6'h15, 6'h2A});
    check("R1 R4 msb-first code", 64'(br1_code), 64'h2A);
    check_all("R4 R10 word0 pattern A");
    write_word(1'b0, {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 6'h3F, 6'h00});
    check("R7 zero code disables bridge1", 64'({br1_off, br2_off}), 64'b10);
    check_all("R4 word0 pattern B");
  endtask

  task automatic t_word1;
    // run=1 test=2 rect=1 osc=3 fast=9 off=0x16 blank=2
    write_word(1'b1, {1'b1, 2'd2, 2'd1, 2'd3, 4'd9, 5'h16, 2'd2});
    check("R5 idle low when D18 set", 64'(idle), 64'h0);
    check_all("R3 R5 word1 written, word0 kept");
    write_word(1'b1, {1'b0, 2'd0, 2'd2, 2'd1, 4'd6, 5'h09, 2'd1});
    check_all("R5 word1 idle request");
  endtask

  task automatic t_bad_count;
    frame({6'd0, 18'h3FFFF}, 18);
    check_all("R6 short frame discarded");
    frame({4'd0, 1'b1, 18'h2AAAA, 1'b0}, 20);
    check_all("R6 long frame discarded");
  endtask

  task automatic t_clk_while_high;
    for (int i = 0; i < 19; i++) begin
      ser_data = 1'b1;
      tick(4);
      ser_clk = 1'b1;
      tick(4);
      ser_clk = 1'b0;
    end
    ser_strobe = 1'b0;
    tick(6);
    ser_strobe = 1'b1;
    tick(6);
    check_all("R1 clocks with strobe high ignored");
  endtask

  task automatic t_abort;
    frame({19'd0, 5'b10101}, 5);
    check_all("R6 aborted partial frame");
    write_word(1'b0, {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 6'h01, 6'h20});
    check_all("R2 full frame after aborted one");
  endtask

  task automatic t_clear;
    sleep_n = 1'b0;
    #1;
    exp_w0 = '0;
    exp_w1 = '0;
    check_all("R8 sleep clears at once");
    tick(3);
    sleep_n = 1'b1;
    tick(4);
    check_all("R8 cleared after sleep");
    write_word(1'b0, {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'h07, 6'h09});
    write_word(1'b1, {1'b1, 2'd0, 2'd3, 2'd0, 4'd15, 5'h1F, 2'd3});
    check_all("R3 both words loaded");
    uvlo = 1'b1;
    #1;
    exp_w0 = '0;
    exp_w1 = '0;
    check_all("R8 undervoltage clears");
    tick(3);
    uvlo = 1'b0;
    tick(4);
    check_all("R8 cleared after undervoltage");
  endtask

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_word0();
    t_word1();
    t_bad_count();
    t_clk_while_high();
    t_abort();
    t_clear();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule